// File: doc/BRIEF.md
# Third-Order Cascaded Fractional Divide Modulator

This block produces, once per comparison-clock cycle, a small signed correction that is added to a synthesizer's integer feedback divide ratio. Over time these corrections average to the programmed 20-bit fraction divided by 2^20, so the loop locks to a non-integer multiple of the reference. The modulator has three first-order accumulators in cascade. Each one integrates the residue of the stage before it, and the three overflow bits are merged by a noise-shaping network of the form c1 + (1 - z^-1)c2 + (1 - z^-1)^2 c3. This network pushes the quantization error of the divide ratio towards high offset frequencies.

A register sits between every pair of accumulators, so no path adds more than one accumulator's carry chain. The earlier stages' carries are delayed so that the three carries merged in one cycle all belong to the same input sample. The fraction word is captured into an input register at a clock edge, so a new fraction enters the pipeline only as a whole sample. The block runs only while the enable is high and the integer-mode select is low. In any other state every register is cleared, the offset is held at zero, and the modulator restarts from that cleared state when it runs again.

Top module: `dsm3_frac_mod`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `offset_o` is zero.
- R2: At a clock edge where `enable_i` is low, every accumulator, delay and history register is cleared, and `offset_o` is zero after that edge.
- R3: At a clock edge where `int_mode_i` is high (integer mode), the block clears exactly as in R2, whatever the fraction and enable are, and `offset_o` is zero after that edge.
- R4: When the block runs again after a cleared edge, it restarts from the cleared state. The same fraction gives the same output sequence as the first run.
- R5: Define carries c1, c2 and c3 by the cascade: s1 += f, s2 += s1, s3 += s2, each modulo 2^20, with a carry when the sum overflows. The fraction sampled at edge t gives y(t) = c1(t) + c2(t) - c2(t-1) + c3(t) - 2*c3(t-1) + c3(t-2). Carries of samples from before the run are zero. y(t) appears on `offset_o` after edge t+4.
- R6: `offset_o` is a 4-bit two's complement value, always in the range -3 to +4.
- R7: With fraction 0x40000 (one quarter), starting from the cleared state, the offsets of the first 4096 samples sum to 1024 within plus or minus 2.
- R8: A fraction of zero gives an offset of zero on every cycle.
- R9: A fraction change is sampled only at a clock edge. Offsets already in the pipeline keep the old fraction, and the new value first affects the output four edges after it is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Comparison-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frac_i | input | 20 | Fraction word, in units of 2^-20 |
| enable_i | input | 1 | Modulator run enable; low clears the block |
| int_mode_i | input | 1 | High selects integer mode and forces a zero offset |
| offset_o | output | 4 | Signed divide-ratio offset, two's complement |

## Verification
A behavioural model of the cascade is compared with the design on every cycle, and the fraction is driven with several patterns. A zero fraction shows that nothing leaks out of the cascade. A constant quarter exposes a wrong first-stage carry or a wrong long-run average through the summed offsets. The full-scale and least-significant fractions reach both ends of the output range and drive the second- and third-stage carries hardest. A fraction that changes every few cycles would catch carries merged from different samples, or a fraction picked up mid-pipeline. Disable and integer-mode pulses in the middle of a run, followed by a repeated run that must match the first, show that the clear is complete and that a restart begins from the cleared state.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   localparam int DSM_ORDER   = 3;
   localparam int DSM_OFS_MIN = -3;
   localparam int DSM_OFS_MAX = 4;

   // delay needed on a stage's carry so all three carries meet the same sample
   function automatic int carry_lag(input int stage);
      return DSM_ORDER - 1 - stage;
   endfunction
endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] add_i,
   output logic [W-1:0] resid_o,
   output logic         carry_o
);
   logic [W:0] sum;

   assign sum = {1'b0, resid_o} + {1'b0, add_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resid_o <= '0;
         carry_o <= 1'b0;
      end else if (clr_i) begin
         resid_o <= '0;
         carry_o <= 1'b0;
      end else begin
         resid_o <= sum[W-1:0];
         carry_o <= sum[W];
      end
   end
endmodule

// File: rtl/dsm_carry_align.sv
module dsm_carry_align #(
   parameter int DEPTH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_dly
         logic [DEPTH-1:0] line;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     line <= '0;
            else if (clr_i) line <= '0;
            else if (DEPTH == 1) line <= d_i;
            else            line <= {line[(DEPTH>1 ? DEPTH-2 : 0):0], d_i};
         end
         assign q_o = line[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/dsm_combine.sv
module dsm_combine #(
   parameter int OUT_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    c1_i,
   input  logic                    c2_i,
   input  logic                    c3_i,
   output logic signed [OUT_W-1:0] ofs_o
);
   logic                    c2_h;
   logic                    c3_h1, c3_h2;
   logic signed [OUT_W-1:0] v1, v2, v2h, v3, v3h1, v3h2, y;

   assign v1   = OUT_W'(c1_i);
   assign v2   = OUT_W'(c2_i);
   assign v2h  = OUT_W'(c2_h);
   assign v3   = OUT_W'(c3_i);
   assign v3h1 = OUT_W'(c3_h1);
   assign v3h2 = OUT_W'(c3_h2);

   // first difference of c2, second difference of c3
   assign y = v1 + (v2 - v2h) + (v3 - (v3h1 <<< 1) + v3h2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c2_h  <= 1'b0;
         c3_h1 <= 1'b0;
         c3_h2 <= 1'b0;
         ofs_o <= '0;
      end else if (clr_i) begin
         c2_h  <= 1'b0;
         c3_h1 <= 1'b0;
         c3_h2 <= 1'b0;
         ofs_o <= '0;
      end else begin
         c2_h  <= c2_i;
         c3_h1 <= c3_i;
         c3_h2 <= c3_h1;
         ofs_o <= y;
      end
   end
endmodule

// File: rtl/dsm3_frac_mod.sv
module dsm3_frac_mod #(
   parameter int FRAC_W = 20,
   parameter int OUT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [FRAC_W-1:0]       frac_i,
   input  logic                    enable_i,
   input  logic                    int_mode_i,
   output logic signed [OUT_W-1:0] offset_o
);
   import dsm_pkg::*;

   localparam int NST = DSM_ORDER;

   generate
      if (FRAC_W < 4 || FRAC_W > 48) begin : g_bad_frac
         $error("dsm3_frac_mod: FRAC_W must lie in 4..48");
      end
      if (OUT_W < 4) begin : g_bad_out
         $error("dsm3_frac_mod: OUT_W must be at least 4 to hold -3..+4");
      end
   endgenerate

   logic              clr;
   logic [FRAC_W-1:0] frac_q;
   logic [FRAC_W-1:0] resid [NST];
   logic              carry [NST];
   logic              carry_al [NST];

   assign clr = ~enable_i | int_mode_i;

   // sample boundary: the fraction enters the cascade only through this register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   frac_q <= '0;
      else if (clr) frac_q <= '0;
      else          frac_q <= frac_i;
   end

   generate
      for (genvar g = 0; g < NST; g++) begin : g_stage
         logic [FRAC_W-1:0] stage_in;
         if (g == 0) begin : g_first
            assign stage_in = frac_q;
         end else begin : g_next
            assign stage_in = resid[g-1];
         end

         dsm_acc_stage #(.W(FRAC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr),
            .add_i   (stage_in),
            .resid_o (resid[g]),
            .carry_o (carry[g])
         );

         dsm_carry_align #(.DEPTH(carry_lag(g))) u_align (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .d_i   (carry[g]),
            .q_o   (carry_al[g])
         );
      end
   endgenerate

   dsm_combine #(.OUT_W(OUT_W)) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .c1_i  (carry_al[0]),
      .c2_i  (carry_al[1]),
      .c3_i  (carry_al[2]),
      .ofs_o (offset_o)
   );
endmodule

// File: rtl/dsm3_frac_mod_chk.sv
module dsm3_frac_mod_chk #(
   parameter int OUT_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    enable_i,
   input logic                    int_mode_i,
   input logic signed [OUT_W-1:0] offset_o
);
   localparam logic signed [OUT_W-1:0] LO = OUT_W'(dsm_pkg::DSM_OFS_MIN);
   localparam logic signed [OUT_W-1:0] HI = OUT_W'(dsm_pkg::DSM_OFS_MAX);

   logic running;
   assign running = enable_i & ~int_mode_i;

   AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (offset_o >= LO) && (offset_o <= HI)); // R6

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (offset_o == '0)); // R2

   AST_INTMODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      int_mode_i |=> (offset_o == '0)); // R3

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !$past(running)) |=> (offset_o == '0)); // R4
endmodule

bind dsm3_frac_mod dsm3_frac_mod_chk #(.OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable_i   (enable_i),
   .int_mode_i (int_mode_i),
   .offset_o   (offset_o)
);

// File: tb/dsm3_frac_mod_tb.sv
`timescale 1ns/1ps
module dsm3_frac_mod_tb;
   localparam int FW  = 20;
   localparam int OW  = 4;
   localparam longint MOD = 64'd1 << FW;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [FW-1:0]        frac = '0;
   logic                 en = 1'b1;
   logic                 imode = 1'b0;
   logic signed [OW-1:0] offset;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    started = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #4 clk = ~clk; // 125 MHz

   dsm3_frac_mod #(.FRAC_W(FW), .OUT_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n), .frac_i(frac),
      .enable_i(en), .int_mode_i(imode), .offset_o(offset)
   );

   // behavioural reference of the cascade (R5)
   longint s1, s2, s3;
   int c2_prev, c3_prev1, c3_prev2;
   int pipe [4];
   int exp_out = 0;

   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n || !en || imode) begin
         s1 = 0; s2 = 0; s3 = 0;
         c2_prev = 0; c3_prev1 = 0; c3_prev2 = 0;
         for (int i = 0; i < 4; i++) pipe[i] = 0;
         exp_out = 0;
      end else begin
         int a, b, c, y;
         s1 = s1 + longint'(frac); a = (s1 >= MOD) ? 1 : 0; s1 = s1 % MOD;
         s2 = s2 + s1;             b = (s2 >= MOD) ? 1 : 0; s2 = s2 % MOD;
         s3 = s3 + s2;             c = (s3 >= MOD) ? 1 : 0; s3 = s3 % MOD;
         y = a + b - c2_prev + c - 2 * c3_prev1 + c3_prev2;
         c2_prev = b; c3_prev2 = c3_prev1; c3_prev1 = c;
         exp_out = pipe[3];
         pipe[3] = pipe[2]; pipe[2] = pipe[1]; pipe[1] = pipe[0]; pipe[0] = y;
      end
   end

   task automatic check(input string req, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   // every-cycle comparison against the model (R5, plus the current phase tag)
   always @(negedge clk) begin
      if (started && !done) begin
         check({"R5/", cur_req}, int'(offset), exp_out);
         if (int'(offset) < -3 || int'(offset) > 4) check("R6 range", int'(offset), 0);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_then_run(input logic [FW-1:0] f);
      en = 1'b0; cyc(1);
      en = 1'b1; frac = f;
   endtask

   int run_a [40];
   int sum;
   logic [31:0] lcg;

   initial begin
      cyc(3);
      cur_req = "R1";
      check("R1 in reset", int'(offset), 0);
      rst_n = 1'b1;
      cyc(1);
      check("R1 after release", int'(offset), 0);

      cur_req = "R8";
      frac = '0;
      cyc(60);
      check("R8 zero fraction", int'(offset), 0);

      // R7: long-run average for one quarter
      cur_req = "R7";
      clear_then_run(20'h40000);
      sum = 0;
      for (int i = 0; i < 4100; i++) begin
         cyc(1);
         sum += int'(offset);
      end
      check("R7 sum lower bound", (sum >= 1022) ? 1 : 0, 1);
      check("R7 sum upper bound", (sum <= 1026) ? 1 : 0, 1);

      // R4: restart from cleared state reproduces the sequence
      cur_req = "R4";
      clear_then_run(20'h5A5A5);
      for (int i = 0; i < 40; i++) begin cyc(1); run_a[i] = int'(offset); end
      cur_req = "R2";
      en = 1'b0;
      cyc(1); check("R2 disabled output", int'(offset), 0);
      cyc(2); check("R2 still disabled", int'(offset), 0);
      cur_req = "R4";
      en = 1'b1;
      for (int i = 0; i < 40; i++) begin
         cyc(1);
         check("R4 restart sequence", int'(offset), run_a[i]);
      end

      // R3: integer mode forces zero even with enable and a nonzero fraction
      cur_req = "R3";
      frac = 20'hFFFFF;
      cyc(20);
      imode = 1'b1;
      for (int i = 0; i < 10; i++) begin
         cyc(1);
         check("R3 integer mode", int'(offset), 0);
      end
      imode = 1'b0;

      // R9: fraction stepping every 7 cycles
      cur_req = "R9";
      lcg = 32'h1234_5678;
      for (int i = 0; i < 300; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         frac = lcg[29:10];
         cyc(7);
      end
      // R9: one clean step checked against the latency
      clear_then_run(20'h00000);
      cyc(10);
      frac = 20'hFFFFF;
      cyc(4);
      check("R9 old fraction still in pipeline", int'(offset), 0);

      // R6: extremes of the fraction
      cur_req = "R6";
      clear_then_run(20'hFFFFF);
      cyc(1500);
      clear_then_run(20'h00001);
      cyc(1500);
      clear_then_run(20'h80001);
      cyc(1500);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule